// File: doc/BRIEF.md
# Channel Start Sync Sequencer

This block decides when one receive processing channel comes out of sleep. A start can be requested by a software sync strobe, by a rising edge on any of four external sync pins, or internally by clearing the sleep bit. Each software or pin source is enabled by its own qualifier bit. All sources can be enabled at once.

A start request does not wake the channel at once. It loads a programmable 16-bit hold-off value into a down-counter. When the counter reaches one, the channel is marked awake. In the same cycle a one-cycle initialise strobe is raised, and the staged channel configuration is copied to the active configuration outputs.

A hold-off value of zero turns a request into a no-op. Setting the sleep bit stops the channel at once. A request that arrives while the channel is already running restarts the count, so several channels can be realigned. The filter and oscillator datapaths are outside the block. They see only the awake flag, the strobe and the active configuration.

Top module: `chan_start_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `awake` and `init_stb` are 0, `cfg_active` is 0, and the hold-off value and all qualifier bits are 0.
- R2: A write selects its register with `wr_sel`. Code 0 is the 16-bit hold-off value. Code 1 is the qualifiers: bit 0 enables the software source, and bits 1..4 enable pins 0..3. Code 2 is the sleep control, using `wr_data[0]`. Code 3 is the staged channel configuration.
- R3: `sw_sync` high at a clock edge is a start request only when qualifier bit 0 is set. Otherwise it has no effect.
- R4: Each sync pin passes through a two-stage synchroniser. A rising edge on a pin whose qualifier bit is set is a start request, loaded at the third clock edge after the pin rises. A pin held high gives exactly one request. Pins whose qualifier is clear have no effect.
- R5: A request loads hold-off value H into the counter at the edge that samples it (software or sleep-write requests: the first edge). `awake` rises and `init_stb` is high for exactly one cycle after the H-th edge following the load. This applies for H from 1 to 65535.
- R6: A request made while the hold-off value is 0 cancels any count in progress. It produces no strobe and leaves `awake` unchanged.
- R7: Writing the sleep control with bit 0 = 1 drives `awake` low at that edge and abandons any count in progress. It wins over any request in the same cycle.
- R8: Writing the sleep control with bit 0 = 0 is a start request whatever the qualifier bits say.
- R9: A request during a count reloads the counter from the hold-off value, and the earlier count gives no strobe. A request while awake produces a new strobe. A request wins over an expiry in the same cycle.
- R10: Writes to the staged configuration do not change `cfg_active`. `cfg_active` takes the staged value only at the edge that raises `init_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| sw_sync | input | 1 | Software sync strobe from the control port |
| sync_pin | input | 4 | Asynchronous external sync inputs |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | Register select (see R2) |
| wr_data | input | 16 | Register write data |
| awake | output | 1 | Channel is running |
| init_stb | output | 1 | One-cycle initialise strobe |
| cfg_active | output | 16 | Configuration applied at the last initialise |

## Verification
The hardest cases to reach are the ones where two events hit the same count. The first is a second request arriving partway through a hold-off. The second is a sleep write landing while a count is still pending. The stimulus sends a software strobe and then, a few cycles later, a second strobe or a sleep write. The scoreboard expects exactly one strobe, timed from the second load, in the first case, and none in the second. A full 65535-cycle hold-off is also run to cover the far end of the counter range.

// File: rtl/chan_start_pkg.sv
package chan_start_pkg;

  typedef enum logic [1:0] {
    SEL_HOLDOFF = 2'd0,
    SEL_QUAL    = 2'd1,
    SEL_SLEEP   = 2'd2,
    SEL_CFG     = 2'd3
  } reg_sel_e;

  localparam int unsigned QUAL_SW_BIT = 0;

endpackage

// File: rtl/sync_rise_det.sv
module sync_rise_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sh_d   = {sh_q[STAGES-2:0], async_in};
    prev_d = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end

  assign rise = sh_q[STAGES-1] & ~prev_q;

  // R4
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/start_ctrl_regs.sv
module start_ctrl_regs
  import chan_start_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned CFG_W    = 16,
  parameter int unsigned NUM_PINS = 4,
  localparam int unsigned QUAL_W  = NUM_PINS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  holdoff_q,
  output logic [QUAL_W-1:0] qual_q,
  output logic [CFG_W-1:0]  shadow_q,
  output logic              sleep_set,
  output logic              sleep_clr
);

  logic [CNT_W-1:0]  holdoff_d;
  logic [QUAL_W-1:0] qual_d;
  logic [CFG_W-1:0]  shadow_d;
  reg_sel_e          sel;

  always_comb begin
    sel       = reg_sel_e'(wr_sel);
    holdoff_d = holdoff_q;
    qual_d    = qual_q;
    shadow_d  = shadow_q;
    sleep_set = 1'b0;
    sleep_clr = 1'b0;
    if (wr_en) begin
      unique case (sel)
        SEL_HOLDOFF: holdoff_d = wr_data[CNT_W-1:0];
        SEL_QUAL:    qual_d    = wr_data[QUAL_W-1:0];
        SEL_SLEEP: begin
          sleep_set = wr_data[0];
          sleep_clr = ~wr_data[0];
        end
        SEL_CFG:     shadow_d  = wr_data[CFG_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdoff_q <= '0;
      qual_q    <= '0;
      shadow_q  <= '0;
    end else begin
      holdoff_q <= holdoff_d;
      qual_q    <= qual_d;
      shadow_q  <= shadow_d;
    end
  end

  // R2
  holdoff_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> holdoff_q == $past(wr_data[CNT_W-1:0]));

endmodule

// File: rtl/holdoff_counter.sv
module holdoff_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             abort,
  input  logic [CNT_W-1:0] preload,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (abort) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else if (load) begin
      if (preload == '0) begin
        cnt_d = '0;
        run_d = 1'b0;
      end else begin
        cnt_d = preload;
        run_d = 1'b1;
      end
    end else if (run_q) begin
      if (cnt_q == ONE) begin
        cnt_d = '0;
        run_d = 1'b0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign expire = run_q && (cnt_q == ONE) && !load && !abort;

  // R5
  no_zero_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q != '0);

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q > ONE && !load && !abort) |=>
      (run_q && cnt_q == CNT_W'($past(cnt_q) - ONE)));

  // R6
  zero_preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !abort && preload == '0) |=> !run_q);

  // R9
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !abort && preload != '0) |=> (run_q && cnt_q == $past(preload)));

endmodule

// File: rtl/chan_start_seq.sv
module chan_start_seq
  import chan_start_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned CFG_W       = 16,
  parameter int unsigned NUM_PINS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_sync,
  input  logic [NUM_PINS-1:0] sync_pin,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                awake,
  output logic                init_stb,
  output logic [CFG_W-1:0]    cfg_active
);

  localparam int unsigned QUAL_W = NUM_PINS + 1;

  logic [CNT_W-1:0]    holdoff_q;
  logic [QUAL_W-1:0]   qual_q;
  logic [CFG_W-1:0]    shadow_q;
  logic                sleep_set;
  logic                sleep_clr;
  logic [NUM_PINS-1:0] pin_rise;
  logic                sw_trig;
  logic                pin_trig;
  logic                start_trig;
  logic                cnt_load;
  logic                expire;

  logic                awake_q, awake_d;
  logic                init_q, init_d;
  logic [CFG_W-1:0]    cfg_act_q, cfg_act_d;

  start_ctrl_regs #(
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .CFG_W    (CFG_W),
    .NUM_PINS (NUM_PINS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .holdoff_q (holdoff_q),
    .qual_q    (qual_q),
    .shadow_q  (shadow_q),
    .sleep_set (sleep_set),
    .sleep_clr (sleep_clr)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    sync_rise_det #(
      .STAGES (SYNC_STAGES)
    ) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (sync_pin[g]),
      .rise     (pin_rise[g])
    );
  end

  always_comb begin
    sw_trig    = sw_sync & qual_q[QUAL_SW_BIT];
    pin_trig   = |(pin_rise & qual_q[QUAL_W-1:1]);
    start_trig = sw_trig | pin_trig | sleep_clr;
    cnt_load   = start_trig & ~sleep_set;
  end

  holdoff_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .abort   (sleep_set),
    .preload (holdoff_q),
    .expire  (expire)
  );

  always_comb begin
    awake_d   = awake_q;
    init_d    = 1'b0;
    cfg_act_d = cfg_act_q;
    if (sleep_set) begin
      awake_d = 1'b0;
    end else if (expire) begin
      awake_d   = 1'b1;
      init_d    = 1'b1;
      cfg_act_d = shadow_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      awake_q   <= 1'b0;
      init_q    <= 1'b0;
      cfg_act_q <= '0;
    end else begin
      awake_q   <= awake_d;
      init_q    <= init_d;
      cfg_act_q <= cfg_act_d;
    end
  end

  assign awake      = awake_q;
  assign init_stb   = init_q;
  assign cfg_active = cfg_act_q;

  // R7
  sleep_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_set |=> (!awake_q && !init_q));

  // R5
  init_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |=> !init_q);

  // R5
  init_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |-> awake_q);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_q |-> $stable(cfg_act_q));

  // R3
  sw_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!qual_q[QUAL_SW_BIT] && !pin_trig && !sleep_clr && !expire) |=> !init_q);

endmodule

// File: tb/test_chan_start_seq.sv
module test_chan_start_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_sync;
  logic [3:0]  sync_pin;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic        awake;
  logic        init_stb;
  logic [15:0] cfg_active;

  always #2.5 clk = ~clk;

  chan_start_seq i_chan_start_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_sync    (sw_sync),
    .sync_pin   (sync_pin),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .awake      (awake),
    .init_stb   (init_stb),
    .cfg_active (cfg_active)
  );

  typedef struct {
    int          at;
    logic [15:0] cfg;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   nchk = 0;
  int   nerr = 0;
  int   t_drv;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input int act, input int expv);
    nchk++;
    if (act != expv) begin
      nerr++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n === 1'b1 && init_stb === 1'b1) begin
      if (exp_q.size() == 0) begin
        nchk++;
        nerr++;
        $display("FAIL R5 unexpected init at cycle actual %0d expected none", cyc);
      end else begin
        e = exp_q.pop_front();
        chk("R5", "init cycle", cyc, e.at);
        chk("R10", "cfg_active at init", int'(cfg_active), int'(e.cfg));
        chk("R5", "awake at init", int'(awake), 1);
      end
    end
  end

  task automatic push_exp(input int at, input logic [15:0] cfg);
    exp_t e;
    e.at  = at;
    e.cfg = cfg;
    exp_q.push_back(e);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    t_drv = cyc;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sw_pulse();
    @(negedge clk);
    sw_sync = 1'b1;
    t_drv = cyc;
    @(negedge clk);
    sw_sync = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string req);
    chk(req, "pending inits", exp_q.size(), 0);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int t2;
    rst_n = 1'b0; sw_sync = 1'b0; sync_pin = 4'b0;
    wr_en = 1'b0; wr_sel = 2'd0; wr_data = 16'd0;
    idle(4);
    chk("R1", "awake in reset", int'(awake), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    chk("R1", "awake after reset", int'(awake), 0);
    chk("R1", "init after reset", int'(init_stb), 0);
    chk("R1", "cfg after reset", int'(cfg_active), 0);

    // R3: software strobe with qualifier clear is ignored
    wr(2'd0, 16'd5);
    sw_pulse();
    idle(12);
    chk("R3", "awake with sw unqualified", int'(awake), 0);

    // R5: software start with hold-off 5
    wr(2'd1, 16'h0001);
    wr(2'd3, 16'hA5A5);
    sw_pulse();
    push_exp(t_drv + 1 + 5, 16'hA5A5);
    idle(10);
    drained("R5");
    chk("R5", "awake after hold-off", int'(awake), 1);

    // R10: staged write does not reach cfg_active
    wr(2'd3, 16'h1234);
    idle(3);
    chk("R10", "cfg before init", int'(cfg_active), 16'hA5A5);

    // R9: request while awake re-initialises
    sw_pulse();
    push_exp(t_drv + 6, 16'h1234);
    idle(10);
    drained("R9");

    // R9: retrigger mid-count
    wr(2'd0, 16'd10);
    sw_pulse();
    idle(3);
    sw_pulse();
    t2 = t_drv;
    push_exp(t2 + 11, 16'h1234);
    idle(20);
    drained("R9");

    // R7: sleep set
    wr(2'd2, 16'h0001);
    chk("R7", "awake after sleep write", int'(awake), 0);

    // R7: sleep aborts count
    sw_pulse();
    idle(3);
    wr(2'd2, 16'h0001);
    idle(20);
    chk("R7", "awake after abort", int'(awake), 0);
    drained("R7");

    // R4 / R2: pin 1 enabled by qualifier bit 2, held high
    wr(2'd1, 16'h0004);
    wr(2'd0, 16'd3);
    @(negedge clk);
    sync_pin[1] = 1'b1;
    t_drv = cyc;
    push_exp(t_drv + 3 + 3, 16'h1234);
    idle(40);
    drained("R4");
    chk("R2", "awake via pin qualifier", int'(awake), 1);
    sync_pin[1] = 1'b0;
    idle(5);

    // R4: unqualified pin ignored
    wr(2'd2, 16'h0001);
    @(negedge clk);
    sync_pin[0] = 1'b1;
    idle(10);
    chk("R4", "awake with pin unqualified", int'(awake), 0);
    sync_pin[0] = 1'b0;
    idle(3);

    // R8: clearing sleep starts regardless of qualifiers
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'd4);
    wr(2'd3, 16'h0F0F);
    wr(2'd2, 16'h0000);
    push_exp(t_drv + 5, 16'h0F0F);
    idle(10);
    drained("R8");
    chk("R8", "awake after sleep clear", int'(awake), 1);

    // R6: zero hold-off defeats start
    wr(2'd2, 16'h0001);
    wr(2'd0, 16'd0);
    wr(2'd2, 16'h0000);
    idle(10);
    chk("R6", "awake with zero hold-off", int'(awake), 0);

    // R5: maximum hold-off
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0001);
    sw_pulse();
    push_exp(t_drv + 1 + 65535, 16'h0F0F);
    idle(65545);
    drained("R5");
    chk("R5", "awake after max hold-off", int'(awake), 1);

    done = 1;
    summary();
    $finish;
  end

endmodule